// File: doc/BRIEF.md
# Sub-Vector Horizontal Reduction Sequencer

This block walks a short vector of packed sub-vectors (each with two to four 64-bit sub-elements, called x, y, z and w) that live in a small internal register file, and reduces them with a chosen integer operation. One start pulse carries the whole job: the element count, the sub-vector length, the mode, the operation, a source base and a destination base, a scalar-destination flag, an optional predicate mask and a condition-record enable. The sequencer then runs by itself, one fold step per clock, and pulses `done` when the last step has landed.

Two modes are offered. In vertical mode every sub-element lane of the destination register acts as its own accumulator, and each lane absorbs the matching lane of every source element in turn. In horizontal mode each source element is folded across its own sub-elements, left to right, into lane x of one destination register per element. In both modes the destination register holds the running value after every step. An interrupt can therefore freeze the job at any step, expose where it stopped, and a later resume carries on from the value already stored in the destination.

A plain lane-wide write and read port gives the surrounding logic access to the register file when no job is stepping.

Top module: `subvec_reduce_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `frozen`, `done` and `cr_valid` are low and every lane of every register reads zero.
- R2: In vertical mode each enabled element i performs, in one clock, dst[k] = op(dst[k], reg[src+i][k]) for every lane k below the sub-vector length, where dst is register `cfg_dst`; higher lanes are left unchanged.
- R3: In horizontal mode element i is folded strictly left to right, op(x,y), then op(partial,z), then op(partial,w), taking sub-vector length minus one clocks; the partial is written to lane x of the destination after every step; lanes y, z and w of the destination are never written.
- R4: `cfg_op` selects 0 = wrapping add, 1 = AND, 2 = OR, 3 = XOR, 4 = signed minimum, 5 = signed maximum; codes 6 and 7 behave as add.
- R5: In horizontal mode with `cfg_cr_en` set, each final reduced result yields exactly one `cr_valid` pulse, in the clock after its write, with `cr_index` equal to the element number and `cr_field` = {lt, gt, eq} (bit 2 = result negative, bit 1 = result positive, bit 0 = result zero, as a signed 64-bit value); partial results and vertical mode yield none.
- R6: With `cfg_pred_en` set, an element whose bit in `cfg_pred` is clear costs one clock and produces no register write and no condition field.
- R7: With `cfg_scalar` set, horizontal results go to register `cfg_dst` itself (no element offset) and the element loop ends after the first enabled element, which is element 0 when `cfg_pred_en` is clear; in horizontal mode without it, element i writes register `cfg_dst + i` (modulo the register count).
- R8: `done` is a one-clock pulse raised at the clock edge that completes the last step; the number of clocks from the start edge to that edge equals the count of fold steps plus skipped elements; a length of zero gives `done` at the start edge with no write.
- R9: When `irq` is high while running, the step of that clock is not performed, `frozen` rises, `step_elem` and `step_sub` show the next pending step and stay stable, and no register is written while frozen.
- R10: A `resume` pulse while frozen continues from the exposed counters, using the current destination contents (including values written through the access port while frozen) as the accumulator.
- R11: The access port write lands only while the block is idle or frozen and is ignored while it is stepping; the read port returns the addressed lane combinationally.
- R12: A start pulse while a job is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a job; taken only when idle |
| cfg_vl | input | 4 | Element count; values above 8 act as 8 |
| cfg_subvl | input | 3 | Sub-vector length 2 to 4; values below 2 act as 2, above 4 as 4 |
| cfg_horiz | input | 1 | 1 = horizontal fold, 0 = vertical per-lane accumulation |
| cfg_op | input | 3 | Operation code (see R4) |
| cfg_src | input | 4 | Source register base |
| cfg_dst | input | 4 | Destination register base |
| cfg_scalar | input | 1 | Scalar destination: single target register and early loop end |
| cfg_pred_en | input | 1 | Apply the predicate mask |
| cfg_pred | input | 8 | Predicate mask, bit i enables element i |
| cfg_cr_en | input | 1 | Emit condition fields for final horizontal results |
| irq | input | 1 | Freeze the running job |
| resume | input | 1 | Continue a frozen job |
| busy | output | 1 | Job running or frozen |
| frozen | output | 1 | Job held by an interrupt |
| done | output | 1 | One-clock pulse at job completion |
| step_elem | output | 4 | Element counter of the pending step |
| step_sub | output | 3 | Sub-element counter of the pending horizontal step |
| cr_valid | output | 1 | Condition field strobe |
| cr_field | output | 3 | {lt, gt, eq} of the final result |
| cr_index | output | 4 | Element the condition field belongs to |
| ext_we | input | 1 | Access port write enable |
| ext_waddr | input | 4 | Access port write register |
| ext_wlane | input | 2 | Access port write lane |
| ext_wdata | input | 64 | Access port write data |
| ext_raddr | input | 4 | Access port read register |
| ext_rlane | input | 2 | Access port read lane |
| ext_rdata | output | 64 | Access port read data |

## Verification
The bench aims at the fold order and the stored partials: it freezes a horizontal job midway, reads lane x, overwrites it and resumes, so a design that kept the partial in a hidden register, or restarted the element, ends with a different sum. Predicated runs with leading clear bits and a scalar destination catch a loop that writes skipped elements, offsets the scalar target or fails to stop after the first enabled element. Signed minimum and maximum on mixed-sign data, and an add that overflows into a negative value, expose unsigned comparison and a wrong less-than flag. Exact done latencies and a start or access-port write pushed in mid-job reveal an extra cycle per skip, a re-triggered job or a write that slips past the running sequencer.

// File: rtl/svr_pkg.sv
package svr_pkg;

    localparam int unsigned DATA_W = 64;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_SMIN = 3'd4,
        OP_SMAX = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } state_e;

    // condition record: bit 2 negative, bit 1 positive, bit 0 zero
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } cond_t;

    function automatic word_t svr_apply(input op_e op, input word_t a, input word_t b);
        word_t r;
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_SMIN: r = ($signed(a) < $signed(b)) ? a : b;
            OP_SMAX: r = ($signed(a) > $signed(b)) ? a : b;
            default: r = a + b;
        endcase
        return r;
    endfunction

    function automatic cond_t svr_cond(input word_t v);
        cond_t c;
        c.lt = v[DATA_W-1];
        c.eq = (v == '0);
        c.gt = !v[DATA_W-1] && (v != '0);
        return c;
    endfunction

endpackage

// File: rtl/svr_regfile.sv
module svr_regfile
    import svr_pkg::*;
#(
    parameter int unsigned NREG  = 16,
    parameter int unsigned LANES = 4,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned LW   = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        src_addr,
    output word_t [LANES-1:0]    src_q,
    input  logic [AW-1:0]        dst_addr,
    output word_t [LANES-1:0]    dst_q,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     wr_mask,
    input  word_t [LANES-1:0]    wr_d,
    input  logic                 ext_we,
    input  logic [AW-1:0]        ext_waddr,
    input  logic [LW-1:0]        ext_wlane,
    input  word_t                ext_wdata,
    input  logic [AW-1:0]        ext_raddr,
    input  logic [LW-1:0]        ext_rlane,
    output word_t                ext_rdata
);

    word_t mem [NREG][LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                for (int l = 0; l < LANES; l++) begin
                    mem[r][l] <= '0;
                end
            end
        end else begin
            if (ext_we) begin
                mem[ext_waddr][ext_wlane] <= ext_wdata;
            end
            if (wr_en) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_mask[l]) begin
                        mem[dst_addr][l] <= wr_d[l];
                    end
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            src_q[l] = mem[src_addr][l];
            dst_q[l] = mem[dst_addr][l];
        end
    end

    assign ext_rdata = mem[ext_raddr][ext_rlane];

endmodule

// File: rtl/svr_lanes.sv
module svr_lanes
    import svr_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  op_e                  op,
    input  word_t [LANES-1:0]    a,
    input  word_t [LANES-1:0]    b,
    output word_t [LANES-1:0]    y
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign y[g] = svr_apply(op, a[g], b[g]);
    end

endmodule

// File: rtl/svr_ctrl.sv
module svr_ctrl
    import svr_pkg::*;
#(
    parameter int unsigned NREG  = 16,
    parameter int unsigned LANES = 4,
    parameter int unsigned MAXVL = 8,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned SVW  = $clog2(LANES + 1),
    localparam int unsigned VLW  = $clog2(MAXVL + 1),
    localparam int unsigned EIW  = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLW-1:0]   cfg_vl,
    input  logic [SVW-1:0]   cfg_subvl,
    input  logic             cfg_horiz,
    input  logic [2:0]       cfg_op,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic             cfg_scalar,
    input  logic             cfg_pred_en,
    input  logic [MAXVL-1:0] cfg_pred,
    input  logic             cfg_cr_en,
    input  logic             irq,
    input  logic             resume,
    output logic             busy,
    output logic             running,
    output logic             frozen,
    output logic             done,
    output logic             do_step,
    output logic             last_sub,
    output logic [VLW-1:0]   elem,
    output logic [SVW-1:0]   sub,
    output logic             horiz,
    output op_e              op,
    output logic [AW-1:0]    src_base,
    output logic [AW-1:0]    dst_base,
    output logic             scalar,
    output logic [SVW-1:0]   subvl,
    output logic             cr_en
);

    state_e           state_q;
    logic [VLW-1:0]   vl_q, elem_q, vl_in;
    logic [SVW-1:0]   subvl_q, sub_q, subvl_in;
    logic             horiz_q, scalar_q, pred_en_q, cr_en_q, done_q;
    op_e              op_q;
    logic [AW-1:0]    src_q, dst_q;
    logic [MAXVL-1:0] pred_q;
    logic [EIW-1:0]   eidx;
    logic             elem_en, elem_done, finish_now;

    assign eidx = elem_q[EIW-1:0];

    always_comb begin
        vl_in    = (cfg_vl > VLW'(MAXVL)) ? VLW'(MAXVL) : cfg_vl;
        if (cfg_subvl < SVW'(2)) begin
            subvl_in = SVW'(2);
        end else if (cfg_subvl > SVW'(LANES)) begin
            subvl_in = SVW'(LANES);
        end else begin
            subvl_in = cfg_subvl;
        end
    end

    always_comb begin
        elem_en    = !pred_en_q || pred_q[eidx];
        last_sub   = !horiz_q || (sub_q == subvl_q - SVW'(1));
        do_step    = (state_q == ST_RUN) && !irq && elem_en;
        elem_done  = (state_q == ST_RUN) && !irq && (!elem_en || last_sub);
        finish_now = elem_done &&
                     (((elem_q + VLW'(1)) >= vl_q) || (scalar_q && elem_en));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b0;
            vl_q      <= '0;
            elem_q    <= '0;
            subvl_q   <= SVW'(2);
            sub_q     <= SVW'(1);
            horiz_q   <= 1'b0;
            scalar_q  <= 1'b0;
            pred_en_q <= 1'b0;
            cr_en_q   <= 1'b0;
            op_q      <= OP_ADD;
            src_q     <= '0;
            dst_q     <= '0;
            pred_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        vl_q      <= vl_in;
                        subvl_q   <= subvl_in;
                        horiz_q   <= cfg_horiz;
                        op_q      <= op_e'(cfg_op);
                        src_q     <= cfg_src;
                        dst_q     <= cfg_dst;
                        scalar_q  <= cfg_scalar;
                        pred_en_q <= cfg_pred_en;
                        pred_q    <= cfg_pred;
                        cr_en_q   <= cfg_cr_en;
                        elem_q    <= '0;
                        sub_q     <= SVW'(1);
                        if (vl_in == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (irq) begin
                        state_q <= ST_FROZEN;
                    end else if (elem_done) begin
                        if (finish_now) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            elem_q <= elem_q + VLW'(1);
                            sub_q  <= SVW'(1);
                        end
                    end else if (do_step) begin
                        sub_q <= sub_q + SVW'(1);
                    end
                end
                ST_FROZEN: begin
                    if (resume) begin
                        state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign running  = (state_q == ST_RUN);
    assign frozen   = (state_q == ST_FROZEN);
    assign done     = done_q;
    assign elem     = elem_q;
    assign sub      = sub_q;
    assign horiz    = horiz_q;
    assign op       = op_q;
    assign src_base = src_q;
    assign dst_base = dst_q;
    assign scalar   = scalar_q;
    assign subvl    = subvl_q;
    assign cr_en    = cr_en_q;

    // R8: completion only ever reported from the idle state
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_q == ST_IDLE));

    // R8: leaving the busy condition is always accompanied by done
    p_busy_fall_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9: a frozen job keeps its step counters until resumed
    p_frozen_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_FROZEN) && !resume) |=>
            ((state_q == ST_FROZEN) && $stable(elem_q) && $stable(sub_q)));

    // R3: the horizontal step index stays within 1 .. length-1
    p_sub_range_r3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RUN) && horiz_q) |->
            ((sub_q >= SVW'(1)) && (sub_q < subvl_q)));

    // R6: a masked-off element never triggers a register write
    p_skip_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RUN) && pred_en_q && !pred_q[eidx]) |-> !do_step);

endmodule

// File: rtl/subvec_reduce_seq.sv
module subvec_reduce_seq
    import svr_pkg::*;
#(
    parameter int unsigned NREG  = 16,
    parameter int unsigned LANES = 4,
    parameter int unsigned MAXVL = 8,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned LW   = $clog2(LANES),
    localparam int unsigned SVW  = $clog2(LANES + 1),
    localparam int unsigned VLW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLW-1:0]   cfg_vl,
    input  logic [SVW-1:0]   cfg_subvl,
    input  logic             cfg_horiz,
    input  logic [2:0]       cfg_op,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic             cfg_scalar,
    input  logic             cfg_pred_en,
    input  logic [MAXVL-1:0] cfg_pred,
    input  logic             cfg_cr_en,
    input  logic             irq,
    input  logic             resume,
    output logic             busy,
    output logic             frozen,
    output logic             done,
    output logic [VLW-1:0]   step_elem,
    output logic [SVW-1:0]   step_sub,
    output logic             cr_valid,
    output logic [2:0]       cr_field,
    output logic [VLW-1:0]   cr_index,
    input  logic             ext_we,
    input  logic [AW-1:0]    ext_waddr,
    input  logic [LW-1:0]    ext_wlane,
    input  logic [63:0]      ext_wdata,
    input  logic [AW-1:0]    ext_raddr,
    input  logic [LW-1:0]    ext_rlane,
    output logic [63:0]      ext_rdata
);

    logic             running, do_step, last_sub, horiz, scalar, cr_en;
    logic [VLW-1:0]   elem;
    logic [SVW-1:0]   sub, subvl;
    logic [LW-1:0]    sub_idx;
    op_e              op;
    logic [AW-1:0]    src_base, dst_base, src_addr, dst_addr;
    word_t [LANES-1:0] src_v, dst_v, a_v, b_v, y_v;
    logic [LANES-1:0] wr_mask;
    logic             ext_we_ok;
    logic             cr_valid_q;
    cond_t            cr_q;
    logic [VLW-1:0]   cr_idx_q;

    svr_ctrl #(.NREG(NREG), .LANES(LANES), .MAXVL(MAXVL)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_vl     (cfg_vl),
        .cfg_subvl  (cfg_subvl),
        .cfg_horiz  (cfg_horiz),
        .cfg_op     (cfg_op),
        .cfg_src    (cfg_src),
        .cfg_dst    (cfg_dst),
        .cfg_scalar (cfg_scalar),
        .cfg_pred_en(cfg_pred_en),
        .cfg_pred   (cfg_pred),
        .cfg_cr_en  (cfg_cr_en),
        .irq        (irq),
        .resume     (resume),
        .busy       (busy),
        .running    (running),
        .frozen     (frozen),
        .done       (done),
        .do_step    (do_step),
        .last_sub   (last_sub),
        .elem       (elem),
        .sub        (sub),
        .horiz      (horiz),
        .op         (op),
        .src_base   (src_base),
        .dst_base   (dst_base),
        .scalar     (scalar),
        .subvl      (subvl),
        .cr_en      (cr_en)
    );

    // element addressing: vertical and scalar jobs keep one accumulator register
    assign sub_idx  = sub[LW-1:0];
    assign src_addr = src_base + AW'(elem);
    assign dst_addr = (horiz && !scalar) ? (dst_base + AW'(elem)) : dst_base;

    for (genvar g = 0; g < LANES; g++) begin : g_mux
        if (g == 0) begin : g_x
            // lane x carries the horizontal fold: first step seeds from source x
            assign a_v[g] = !horiz ? dst_v[g] :
                            (sub == SVW'(1)) ? src_v[0] : dst_v[0];
            assign b_v[g] = horiz ? src_v[sub_idx] : src_v[g];
            assign wr_mask[g] = 1'b1;
        end else begin : g_yzw
            assign a_v[g] = dst_v[g];
            assign b_v[g] = src_v[g];
            assign wr_mask[g] = !horiz && (SVW'(g) < subvl);
        end
    end

    svr_lanes #(.LANES(LANES)) u_lanes (
        .op(op),
        .a (a_v),
        .b (b_v),
        .y (y_v)
    );

    assign ext_we_ok = ext_we && !running;

    svr_regfile #(.NREG(NREG), .LANES(LANES)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .src_addr (src_addr),
        .src_q    (src_v),
        .dst_addr (dst_addr),
        .dst_q    (dst_v),
        .wr_en    (do_step),
        .wr_mask  (wr_mask),
        .wr_d     (y_v),
        .ext_we   (ext_we_ok),
        .ext_waddr(ext_waddr),
        .ext_wlane(ext_wlane),
        .ext_wdata(ext_wdata),
        .ext_raddr(ext_raddr),
        .ext_rlane(ext_rlane),
        .ext_rdata(ext_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_valid_q <= 1'b0;
            cr_q       <= '0;
            cr_idx_q   <= '0;
        end else begin
            cr_valid_q <= do_step && horiz && last_sub && cr_en;
            cr_q       <= svr_cond(y_v[0]);
            cr_idx_q   <= elem;
        end
    end

    assign cr_valid  = cr_valid_q;
    assign cr_field  = cr_q;
    assign cr_index  = cr_idx_q;
    assign step_elem = elem;
    assign step_sub  = sub;

    // R5: a condition field always follows a register write
    p_cr_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        cr_valid |-> $past(do_step));

    // R9: nothing is written into the register file by the sequencer while frozen
    p_frozen_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        frozen |-> !do_step);

    // R5: condition fields carry exactly one of the three flags
    p_cr_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        cr_valid |-> ($countones(cr_field) == 1));

endmodule

// File: tb/subvec_reduce_seq_tb.sv
module subvec_reduce_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  cfg_vl = '0;
    logic [2:0]  cfg_subvl = 3'd2;
    logic        cfg_horiz = 1'b0;
    logic [2:0]  cfg_op = '0;
    logic [3:0]  cfg_src = '0;
    logic [3:0]  cfg_dst = '0;
    logic        cfg_scalar = 1'b0;
    logic        cfg_pred_en = 1'b0;
    logic [7:0]  cfg_pred = '0;
    logic        cfg_cr_en = 1'b0;
    logic        irq = 1'b0;
    logic        resume = 1'b0;
    logic        busy, frozen, done, cr_valid;
    logic [3:0]  step_elem, cr_index;
    logic [2:0]  step_sub, cr_field;
    logic        ext_we = 1'b0;
    logic [3:0]  ext_waddr = '0;
    logic [1:0]  ext_wlane = '0;
    logic [63:0] ext_wdata = '0;
    logic [3:0]  ext_raddr = '0;
    logic [1:0]  ext_rlane = '0;
    logic [63:0] ext_rdata;

    int checks = 0;
    int errors = 0;

    logic [63:0] shadow [16][4];

    typedef struct {
        int         idx;
        logic [2:0] fld;
    } cr_item_t;
    cr_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    subvec_reduce_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_vl(cfg_vl), .cfg_subvl(cfg_subvl),
        .cfg_horiz(cfg_horiz), .cfg_op(cfg_op), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_scalar(cfg_scalar), .cfg_pred_en(cfg_pred_en), .cfg_pred(cfg_pred),
        .cfg_cr_en(cfg_cr_en), .irq(irq), .resume(resume), .busy(busy), .frozen(frozen),
        .done(done), .step_elem(step_elem), .step_sub(step_sub), .cr_valid(cr_valid),
        .cr_field(cr_field), .cr_index(cr_index), .ext_we(ext_we), .ext_waddr(ext_waddr),
        .ext_wlane(ext_wlane), .ext_wdata(ext_wdata), .ext_raddr(ext_raddr),
        .ext_rlane(ext_rlane), .ext_rdata(ext_rdata)
    );

    function automatic logic [63:0] ref_op(int op, logic [63:0] a, logic [63:0] b);
        case (op)
            1: return a & b;
            2: return a | b;
            3: return a ^ b;
            4: return ($signed(a) <= $signed(b)) ? a : b;
            5: return ($signed(a) >= $signed(b)) ? a : b;
            default: return a + b;
        endcase
    endfunction

    function automatic logic [2:0] ref_cond(logic [63:0] v);
        if ($signed(v) < 0) return 3'b100;
        if (v == 64'd0)     return 3'b001;
        return 3'b010;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor for condition fields
    always @(negedge clk) begin
        if (!rst && cr_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected condition field actual=%0h expected=none", cr_field);
            end else begin
                cr_item_t it;
                it = exp_q.pop_front();
                if (cr_field !== it.fld || cr_index !== 4'(it.idx)) begin
                    errors++;
                    $display("FAIL R5 condition field actual=%0h/%0d expected=%0h/%0d",
                             cr_field, cr_index, it.fld, it.idx);
                end
            end
        end
    end

    task automatic poke(input int r, input int l, input logic [63:0] v);
        @(negedge clk);
        ext_we = 1'b1; ext_waddr = 4'(r); ext_wlane = 2'(l); ext_wdata = v;
        @(negedge clk);
        ext_we = 1'b0;
        shadow[r][l] = v;
    endtask

    task automatic compare_all(input string req);
        int bad = 0;
        @(negedge clk);
        for (int r = 0; r < 16; r++) begin
            for (int l = 0; l < 4; l++) begin
                ext_raddr = 4'(r); ext_rlane = 2'(l);
                #1;
                if (ext_rdata !== shadow[r][l]) begin
                    bad++;
                    $display("FAIL %s reg %0d lane %0d actual=%0h expected=%0h",
                             req, r, l, ext_rdata, shadow[r][l]);
                end
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic model_op(input int vl, input int subvl, input bit hz, input int op,
                            input int src, input int dst, input bit sc, input bit pen,
                            input logic [7:0] pred, input bit cre, output int steps);
        steps = 0;
        for (int e = 0; e < vl; e++) begin
            if (pen && !pred[e]) begin
                steps++;
                continue;
            end
            if (hz) begin
                logic [63:0] acc;
                int s = (src + e) % 16;
                int d = sc ? dst : (dst + e) % 16;
                acc = shadow[s][0];
                for (int k = 1; k < subvl; k++) acc = ref_op(op, acc, shadow[s][k]);
                steps += subvl - 1;
                shadow[d][0] = acc;
                if (cre) begin
                    cr_item_t it;
                    it.idx = e; it.fld = ref_cond(acc);
                    exp_q.push_back(it);
                end
            end else begin
                for (int k = 0; k < subvl; k++)
                    shadow[dst][k] = ref_op(op, shadow[dst][k], shadow[(src + e) % 16][k]);
                steps++;
            end
            if (sc) break;
        end
    endtask

    task automatic launch(input int vl, input int subvl, input bit hz, input int op,
                          input int src, input int dst, input bit sc, input bit pen,
                          input logic [7:0] pred, input bit cre);
        @(negedge clk);
        cfg_vl = 4'(vl); cfg_subvl = 3'(subvl); cfg_horiz = hz; cfg_op = 3'(op);
        cfg_src = 4'(src); cfg_dst = 4'(dst); cfg_scalar = sc; cfg_pred_en = pen;
        cfg_pred = pred; cfg_cr_en = cre;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int exp_n, input string req);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_n, req, "done latency", 64'(n), 64'(exp_n));
        @(negedge clk);
        chk(!done && !busy, "R8", "done single pulse / idle", {62'd0, done, busy}, 64'd0);
        chk(exp_q.size() == 0, req, "pending condition fields", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic run_op(input int vl, input int subvl, input bit hz, input int op,
                          input int src, input int dst, input bit sc, input bit pen,
                          input logic [7:0] pred, input bit cre, input string req);
        int steps;
        model_op(vl, subvl, hz, op, src, dst, sc, pen, pred, cre, steps);
        launch(vl, subvl, hz, op, src, dst, sc, pen, pred, cre);
        wait_done(steps, req);
        compare_all(req);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int steps;
        for (int r = 0; r < 16; r++)
            for (int l = 0; l < 4; l++) shadow[r][l] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs and cleared register file
        chk(!busy && !frozen && !done && !cr_valid, "R1", "idle outputs after reset",
            {60'd0, busy, frozen, done, cr_valid}, 64'd0);
        compare_all("R1");

        // R11: load through the access port while idle
        for (int r = 0; r < 7; r++)
            for (int l = 0; l < 4; l++)
                poke(r, l, 64'(longint'((r * 37 + l * 11) % 53) - 26));
        poke(7, 0, 64'h7FFF_FFFF_FFFF_FFFF);
        poke(7, 1, 64'd5);
        poke(7, 2, 64'hFFFF_FFFF_FFFF_FFF0);
        poke(7, 3, 64'd3);
        compare_all("R11");

        // R2 vertical add over two lanes; R4 add
        run_op(3, 2, 1'b0, 0, 0, 10, 1'b0, 1'b0, 8'h00, 1'b0, "R2");
        // R2/R6/R5 vertical xor, predicated, condition enable has no effect
        run_op(5, 4, 1'b0, 3, 1, 11, 1'b0, 1'b1, 8'b0001_0110, 1'b1, "R6");
        // R3/R5 horizontal add, length 3
        run_op(4, 3, 1'b1, 0, 0, 12, 1'b0, 1'b0, 8'h00, 1'b1, "R3");
        // R4 signed min and max, length 4
        run_op(3, 4, 1'b1, 4, 4, 8, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
        run_op(2, 4, 1'b1, 5, 2, 13, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
        // R4 and / or / reserved codes as add (wraps negative)
        run_op(2, 2, 1'b1, 1, 3, 14, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
        run_op(1, 3, 1'b1, 2, 5, 10, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
        run_op(1, 2, 1'b1, 6, 7, 12, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
        run_op(1, 4, 1'b1, 7, 1, 9, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
        // R7 scalar horizontal, first enabled element is 2
        run_op(6, 2, 1'b1, 0, 0, 9, 1'b1, 1'b1, 8'b0010_0100, 1'b1, "R7");
        // R7 scalar vertical without predicate stops after element 0
        run_op(5, 3, 1'b0, 0, 1, 11, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
        // R8 zero length
        run_op(0, 4, 1'b1, 0, 0, 8, 1'b0, 1'b0, 8'h00, 1'b1, "R8");

        // R9/R10 interrupt mid-fold, modify accumulator, resume
        poke(3, 0, 64'd10); poke(3, 1, 64'd20); poke(3, 2, 64'd30); poke(3, 3, 64'd40);
        launch(1, 4, 1'b1, 0, 3, 15, 1'b0, 1'b0, 8'h00, 1'b1);
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        chk(frozen && busy, "R9", "frozen after irq", {62'd0, frozen, busy}, 64'd3);
        chk(step_elem == 4'd0 && step_sub == 3'd2, "R9", "step counters",
            {57'd0, step_elem, step_sub}, {57'd0, 4'd0, 3'd2});
        ext_raddr = 4'd15; ext_rlane = 2'd0;
        #1;
        chk(ext_rdata == 64'd30, "R3", "stored partial x+y", ext_rdata, 64'd30);
        repeat (2) @(negedge clk);
        chk(frozen && step_sub == 3'd2 && ext_rdata == 64'd30, "R9", "held while frozen",
            ext_rdata, 64'd30);
        poke(15, 0, 64'd100);
        ext_raddr = 4'd15; ext_rlane = 2'd0;
        #1;
        chk(ext_rdata == 64'd100, "R11", "write while frozen", ext_rdata, 64'd100);
        begin
            cr_item_t it;
            it.idx = 0; it.fld = 3'b010;
            exp_q.push_back(it);
        end
        shadow[15][0] = 64'd170;
        @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        wait_done(2, "R10");
        compare_all("R10");

        // R11/R12 access write and second start ignored while stepping
        model_op(4, 4, 1'b1, 5, 0, 8, 1'b0, 1'b0, 8'h00, 1'b0, steps);
        launch(4, 4, 1'b1, 5, 0, 8, 1'b0, 1'b0, 8'h00, 1'b0);
        ext_we = 1'b1; ext_waddr = 4'd5; ext_wlane = 2'd3; ext_wdata = 64'hDEAD;
        cfg_vl = 4'd0; start = 1'b1;
        @(negedge clk);
        ext_we = 1'b0; start = 1'b0;
        wait_done(steps - 1, "R12");
        compare_all("R11");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule